// File: doc/BRIEF.md
# Configuration Stream Target Filter

This block sits between the configuration stream front end and configuration memory. It decides whether the stream currently arriving is meant for this chip. It compares the identifier carried in each stream header with a short chip identifier strapped on pins, and forwards configuration words to memory only while the latest header was addressed to this chip.

- A header whose identifier is all ones is a broadcast, and every chip accepts it.
- A header aimed at another chip blocks loading and is reported as an error event.

Uncorrectable faults found during processing are reported by address. An address that has already been reported is remembered in a small suppression list, so that a stuck fault cannot keep the outputs asserted. Each error event becomes a one-cycle pulse on two outputs, and each output has its own mask.

Top module: `devid_gate`

## Requirements
- R1: The 4-bit pin identifier is captured at the first clock edge after reset is released. Later changes on the pins have no effect until the next reset.
- R2: A header is accepted when stream ID bits [7:4] are zero and bits [3:0] equal the captured pin identifier. Any other non-broadcast value is rejected.
- R3: A header with stream ID 0xFF is accepted whatever the pin identifier.
- R4: `cfg_we` equals `word_valid` while the most recent header was accepted, and `cfg_wdata` carries `word_data` unchanged.
  - The decision is registered when `hdr_valid` is high and holds until the next header.
  - A word that arrives in the same cycle as a header uses the previous decision.
  - After reset, before any header, no word is written.
- R5: A rejected header blocks all writes until an accepted header arrives, and it counts as one error event.
- R6: An error event in cycle t drives `err_pulse` high in cycle t+1 only, unless `err_mask` is high in cycle t.
- R7: An error event in cycle t drives `trig_pulse` high in cycle t+1 only, unless `trig_mask` is high in cycle t. The two masks are independent.
- R8: An uncorrectable fault at an address not yet recorded is an error event and is recorded. Later faults at a recorded address produce no pulse until reset.
- R9: Once `BL_DEPTH` addresses are recorded, faults at new addresses produce no pulse.
- R10: A header rejection and a new fault in the same cycle produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_id | input | 4 | Strapped chip identifier |
| hdr_valid | input | 1 | Stream header identifier valid |
| hdr_id | input | 8 | Identifier carried by the stream header |
| word_valid | input | 1 | Configuration word valid |
| word_data | input | DATA_W | Configuration word |
| fault_valid | input | 1 | Uncorrectable fault reported |
| fault_addr | input | ADDR_W | Address of the reported fault |
| err_mask | input | 1 | Suppresses pulses on err_pulse |
| trig_mask | input | 1 | Suppresses pulses on trig_pulse |
| cfg_we | output | 1 | Gated write enable to configuration memory |
| cfg_wdata | output | DATA_W | Write data to configuration memory |
| err_pulse | output | 1 | One-cycle error pulse |
| trig_pulse | output | 1 | One-cycle trigger pulse |

## Verification
A wrongly latched accept flag appears on `cfg_we` at the first word after a header, so every header in the bench is followed by a probe word. A bad captured pin identifier appears only at the next header, which is why the pins are changed after reset and headers for both the old and new values are sent. Suppression-list faults, such as a lost entry, a wrong free slot or a wrong full test, appear one cycle after a repeated or overflowing fault address as an extra or missing pulse.

// File: rtl/devid_gate_pkg.sv
package devid_gate_pkg;
  localparam int PIN_ID_W    = 4;
  localparam int STREAM_ID_W = 8;
  typedef logic [PIN_ID_W-1:0]    pin_id_t;
  typedef logic [STREAM_ID_W-1:0] stream_id_t;
  localparam stream_id_t BCAST_ID = '1;
  localparam int N_PULSE = 2;
  typedef enum int {PO_ERR = 0, PO_TRIG = 1} pulse_out_e;
endpackage

// File: rtl/devid_match.sv
module devid_match
  import devid_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pin_id_t    pin_id,
  input  logic       hdr_valid,
  input  stream_id_t hdr_id,
  output logic       accept,
  output logic       mismatch_ev
);
  logic    armed_q, armed_d;
  pin_id_t id_q, id_d, id_eff;
  logic    acc_q, acc_d;
  logic    hit;

  always_comb begin
    id_eff = armed_q ? id_q : pin_id;
    hit = (hdr_id == BCAST_ID) ||
          ((hdr_id[STREAM_ID_W-1:PIN_ID_W] == '0) && (hdr_id[PIN_ID_W-1:0] == id_eff));
    armed_d     = 1'b1;
    id_d        = id_eff;
    acc_d       = hdr_valid ? hit : acc_q;
    mismatch_ev = hdr_valid && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      id_q    <= '0;
      acc_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (!armed_q) id_q <= id_d;
      if (hdr_valid) acc_q <= acc_d;
    end
  end

  assign accept = acc_q;
endmodule

// File: rtl/devid_blacklist.sv
module devid_blacklist #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic              new_fault
);
  logic [DEPTH-1:0]  vld_q, vld_d, hit_vec, free_first;
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic              any_hit, full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == fault_addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q[i] <= '0;
      else if (new_fault && free_first[i]) tag_q[i] <= fault_addr;
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    free_first = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_first[i] = 1'b1;
        found         = 1'b1;
      end
    end
    any_hit   = |hit_vec;
    full      = &vld_q;
    new_fault = fault_valid && !any_hit && !full;
    vld_d     = vld_q | (new_fault ? free_first : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (new_fault) vld_q <= vld_d;
  end
endmodule

// File: rtl/devid_pulse.sv
module devid_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  input  logic mask,
  output logic pulse
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = event_in && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/devid_gate.sv
module devid_gate
  import devid_gate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int BL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        pin_id,
  input  logic              hdr_valid,
  input  logic [7:0]        hdr_id,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              fault_valid,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              err_mask,
  input  logic              trig_mask,
  output logic              cfg_we,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              err_pulse,
  output logic              trig_pulse
);
  logic               accept, mismatch_ev, new_fault, any_ev;
  logic [N_PULSE-1:0] masks, pulses;

  devid_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_id      (pin_id),
    .hdr_valid   (hdr_valid),
    .hdr_id      (hdr_id),
    .accept      (accept),
    .mismatch_ev (mismatch_ev)
  );

  devid_blacklist #(.ADDR_W(ADDR_W), .DEPTH(BL_DEPTH)) u_bl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_valid (fault_valid),
    .fault_addr  (fault_addr),
    .new_fault   (new_fault)
  );

  assign any_ev         = mismatch_ev || new_fault;
  assign masks[PO_ERR]  = err_mask;
  assign masks[PO_TRIG] = trig_mask;

  for (genvar k = 0; k < N_PULSE; k++) begin : g_pulse
    devid_pulse u_p (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_in (any_ev),
      .mask     (masks[k]),
      .pulse    (pulses[k])
    );
  end

  assign err_pulse  = pulses[PO_ERR];
  assign trig_pulse = pulses[PO_TRIG];
  assign cfg_we     = word_valid && accept;
  assign cfg_wdata  = word_data;
endmodule

// File: rtl/devid_gate_chk.sv
module devid_gate_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int BL_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        pin_id,
  input logic              hdr_valid,
  input logic [7:0]        hdr_id,
  input logic              word_valid,
  input logic [DATA_W-1:0] word_data,
  input logic              fault_valid,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              err_mask,
  input logic              trig_mask,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              err_pulse,
  input logic              trig_pulse
);
  // R4: a write enable never appears without a word
  a_r4_we_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> word_valid);

  // R4: write data passes through unchanged
  a_r4_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_wdata == word_data));

  // R3: after a broadcast header every word is written
  a_r3_bcast_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_id == 8'hFF) |=> (!word_valid || cfg_we || hdr_valid));

  // R5: a header with a nonzero upper nibble (not broadcast) blocks the next word
  a_r5_foreign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_id != 8'hFF && hdr_id[7:4] != 4'h0) |=> !cfg_we);

  // R6: no error pulse follows a cycle with the error mask set
  a_r6_err_mask: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !$past(err_mask));

  // R7: no trigger pulse follows a cycle with the trigger mask set
  a_r7_trig_mask: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !$past(trig_mask));

  // R8: a fault repeated at the same address raises nothing
  a_r8_repeat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && $past(fault_valid) && fault_addr == $past(fault_addr) && !hdr_valid)
      |=> (!err_pulse && !trig_pulse));
endmodule

bind devid_gate devid_gate_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BL_DEPTH(BL_DEPTH)) u_chk (.*);

// File: tb/sim_devid_gate.sv
`timescale 1ns/1ps
module sim_devid_gate;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int BL_DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] pin_id;
  logic hdr_valid;
  logic [7:0] hdr_id;
  logic word_valid;
  logic [DATA_W-1:0] word_data;
  logic fault_valid;
  logic [ADDR_W-1:0] fault_addr;
  logic err_mask, trig_mask;
  logic cfg_we;
  logic [DATA_W-1:0] cfg_wdata;
  logic err_pulse, trig_pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  devid_gate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BL_DEPTH(BL_DEPTH)) u0 (.*);

  // {hdr_id, accepted, error pulse}; pin identifier is 4'hA
  localparam logic [9:0] VEC [8] = '{
    {8'h0A, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0},
    {8'h1A, 1'b0, 1'b1},
    {8'h0B, 1'b0, 1'b1},
    {8'hAA, 1'b0, 1'b1},
    {8'h0F, 1'b0, 1'b1},
    {8'hFA, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [3:0] pid);
    @(negedge clk);
    rst_n = 1'b0; pin_id = pid;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // sends a header, checks both pulses one cycle later and that they last one cycle
  task automatic send_hdr(input logic [7:0] id, input logic exp_err,
                          input logic exp_trig, input string req);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = id;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk(err_pulse, exp_err, req);
    chk(trig_pulse, exp_trig, req);
    @(negedge clk);
    chk(err_pulse, 1'b0, req);
    chk(trig_pulse, 1'b0, req);
  endtask

  task automatic probe_word(input logic exp_we, input string req);
    word_valid = 1'b1; word_data = $urandom;
    #1;
    chk(cfg_we, exp_we, req);
    if (exp_we) begin
      checks++;
      if (cfg_wdata !== word_data) begin
        errors++;
        $display("FAIL R4 data actual=%h expected=%h", cfg_wdata, word_data);
      end
    end
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic send_fault(input logic [ADDR_W-1:0] a, input logic exp, input string req);
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = a;
    @(negedge clk);
    fault_valid = 1'b0;
    chk(err_pulse, exp, req);
    chk(trig_pulse, exp, req);
    @(negedge clk);
    chk(err_pulse, 1'b0, req);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_id = 4'hA; hdr_valid = 1'b0; hdr_id = '0;
    word_valid = 1'b0; word_data = '0; fault_valid = 1'b0; fault_addr = '0;
    err_mask = 1'b0; trig_mask = 1'b0;
    do_reset(4'hA);

    // reset state and no writes before any header (R4)
    chk(err_pulse, 1'b0, "R6 reset");
    chk(trig_pulse, 1'b0, "R7 reset");
    probe_word(1'b0, "R4 no header yet");

    // table walk: R2 matching, R3 broadcast, R5 rejection
    foreach (VEC[i]) begin
      send_hdr(VEC[i][9:2], VEC[i][0], VEC[i][0], "R2/R3/R5 header");
      probe_word(VEC[i][1], "R2/R3/R5 gate");
    end

    // R1: pins change after capture; old value still matches
    pin_id = 4'h5;
    send_hdr(8'h05, 1'b1, 1'b1, "R1 new pins ignored");
    probe_word(1'b0, "R1 new pins ignored");
    send_hdr(8'h0A, 1'b0, 1'b0, "R1 captured id");
    probe_word(1'b1, "R1 captured id");

    // R4: word in the header cycle uses the previous decision; held afterwards
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = 8'h33; word_valid = 1'b1;
    #1 chk(cfg_we, 1'b1, "R4 same cycle old decision");
    @(negedge clk);
    hdr_valid = 1'b0; word_valid = 1'b0;
    @(negedge clk);
    probe_word(1'b0, "R5 held reject");
    probe_word(1'b0, "R5 held reject again");

    // R6 / R7 masks
    err_mask = 1'b1;
    send_hdr(8'h44, 1'b0, 1'b1, "R6 err masked");
    err_mask = 1'b0; trig_mask = 1'b1;
    send_hdr(8'h44, 1'b1, 1'b0, "R7 trig masked");
    trig_mask = 1'b0;

    // R8: once only per address
    send_fault(16'h0003, 1'b1, "R8 first fault");
    send_fault(16'h0003, 1'b0, "R8 repeat fault");
    // R9: fill the list then overflow
    send_fault(16'h0001, 1'b1, "R9 fill");
    send_fault(16'h0002, 1'b1, "R9 fill");
    send_fault(16'h0004, 1'b1, "R9 fill");
    send_fault(16'h0005, 1'b0, "R9 list full");
    send_fault(16'h0002, 1'b0, "R8 repeat");

    // R8: reset clears the list
    do_reset(4'hA);
    send_fault(16'h0003, 1'b1, "R8 after reset");

    // R10: header rejection and new fault together give one pulse
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = 8'h22; fault_valid = 1'b1; fault_addr = 16'h0009;
    @(negedge clk);
    hdr_valid = 1'b0; fault_valid = 1'b0;
    chk(err_pulse, 1'b1, "R10 combined");
    @(negedge clk);
    chk(err_pulse, 1'b0, "R10 single cycle");
    chk(trig_pulse, 1'b0, "R10 single cycle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule